// File: doc/BRIEF.md
# BCD Digit Subtractor with Nines/Tens Complement Methods

This block takes two single decimal digits held in 4-bit BCD form and produces the magnitude and sign of their difference, minuend minus subtrahend. It never subtracts directly. The subtrahend is turned into its nines complement by inverting the bits and adding binary 1010. That value is summed with the minuend in a decimal-corrected adder. A final stage then either folds the decimal carry back in or takes the complement of the sum again. Which of these it does depends on the selected method and on whether a decimal carry appeared.

A method select picks one of two schemes. The nines-complement scheme uses an end-around carry. The tens-complement scheme adds one at the input and discards the carry. Both schemes give the same answer for every legal pair of digits. A digit code above nine raises a flag and the other outputs are then meaningless. The arithmetic is purely combinational. A single output register captures the result on a cycle where the operation enable is high and holds it on all other cycles. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `bcd_digit_subtractor`

## Requirements
- R1: While reset is applied, and after it is released until the first enabled operation, diff_mag, diff_neg and bad_digit are all 0.
- R2: The outputs change only on the clock edge after a cycle with op_en high. While op_en is low they keep their values, whatever dig_a, dig_b and use_tens do.
- R3: With use_tens = 0 (nines-complement method) and both digits in 0..9, the registered diff_mag equals |dig_a − dig_b| and diff_neg is 1 exactly when dig_a < dig_b.
- R4: With use_tens = 1 (tens-complement method) and both digits in 0..9, diff_mag equals |dig_a − dig_b| and diff_neg is 1 exactly when dig_a < dig_b.
- R5: When dig_a equals dig_b, diff_mag is 0 and diff_neg is 0 in both methods. No negative zero is ever output.
- R6: bad_digit is 1 after an operation in which dig_a or dig_b held a code from 10 to 15, and 0 after an operation in which both were in 0..9.
- R7: For legal digits, every internal decimal sum and the final diff_mag lie in 0..9. A decimal carry is reported when the binary sum has a carry, or when bit 3 is set together with bit 2 or bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_en | input | 1 | Capture the result of the present inputs on the next edge |
| dig_a | input | 4 | Minuend BCD digit |
| dig_b | input | 4 | Subtrahend BCD digit |
| use_tens | input | 1 | Method select: 0 nines complement, 1 tens complement |
| diff_mag | output | 4 | BCD magnitude of dig_a − dig_b |
| diff_neg | output | 1 | 1 when the difference is negative |
| bad_digit | output | 1 | 1 when an input code was above 9 |

## Verification
The bench drives every legal pair of digits through both methods, so each case of the decimal carry is covered. The equal-digit case matters most in the nines-complement method. There the sum is exactly nine with no carry, and a design that recomplements it without a sign guard would report a negative zero. Sums just above nine, such as 9 − 0 or 5 − 4, exercise the end-around increment. A design that wraps this increment in plain binary would output codes from 10 to 15 or be off by one. Illegal codes on either input check the flag. Input changes while op_en is low and a reset in the middle of the run check the hold and clear behaviour.

// File: rtl/bcd_sub_pkg.sv
`timescale 1ns/1ps
package bcd_sub_pkg;
  localparam int BCD_W     = 4;
  localparam int RADIX     = 10;
  localparam int DEC_MAX   = RADIX - 1;
  localparam int CORR_ADD  = (1 << BCD_W) - RADIX;
  localparam int NINES_ADD = RADIX;

  typedef logic [BCD_W-1:0] bcd_t;

  typedef enum logic {
    METH_NINES = 1'b0,
    METH_TENS  = 1'b1
  } method_e;

  typedef struct packed {
    bcd_t mag;
    logic neg;
    logic bad;
  } sub_res_t;
endpackage

// File: rtl/bcd_nines_comp.sv
`timescale 1ns/1ps
module bcd_nines_comp
  import bcd_sub_pkg::*;
#(
  parameter int W = BCD_W
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] ADD_K = W'(NINES_ADD);

  logic [W-1:0] inv_d;

  always_comb begin
    inv_d = ~din;
    dout  = inv_d + ADD_K;
  end

  always_comb begin
    if (int'(din) <= DEC_MAX) begin
      AST_NINES_PAIR: assert (int'(dout) + int'(din) == DEC_MAX); // R3
    end
  end
endmodule

// File: rtl/bcd_digit_adder.sv
`timescale 1ns/1ps
module bcd_digit_adder
  import bcd_sub_pkg::*;
#(
  parameter int W = BCD_W
) (
  input  logic [W-1:0] add_x,
  input  logic [W-1:0] add_y,
  input  logic         add_cin,
  output logic [W-1:0] add_sum,
  output logic         add_dcarry
);
  localparam logic [W-1:0] CORR_K = W'(CORR_ADD);

  logic [W:0]   raw_sum;
  logic         over_nine;
  logic [W-1:0] corr_val;

  always_comb begin
    raw_sum   = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
    over_nine = raw_sum[W] | (raw_sum[W-1] & (raw_sum[W-2] | raw_sum[W-3]));
    corr_val  = over_nine ? CORR_K : '0;
  end

  always_comb begin
    add_sum    = raw_sum[W-1:0] + corr_val;
    add_dcarry = over_nine;
  end

  always_comb begin
    if (int'(add_x) <= DEC_MAX && int'(add_y) <= DEC_MAX) begin
      AST_ADD_DIGIT_RANGE: assert (int'(add_sum) <= DEC_MAX); // R7
      AST_ADD_CARRY_RULE: assert (add_dcarry ==
        (int'(add_x) + int'(add_y) + int'(add_cin) > DEC_MAX)); // R7
    end
  end
endmodule

// File: rtl/bcd_sub_finish.sv
`timescale 1ns/1ps
module bcd_sub_finish
  import bcd_sub_pkg::*;
#(
  parameter int W = BCD_W
) (
  input  logic [W-1:0] fin_sum,
  input  logic         fin_dcarry,
  input  logic         fin_tens,
  input  logic         fin_legal,
  output logic [W-1:0] fin_mag,
  output logic         fin_neg
);
  logic [W-1:0] sum_comp;
  logic [W-1:0] pre_val;
  logic         inc_one;
  logic [W-1:0] inc_sum;
  logic         inc_wrap;

  bcd_nines_comp #(.W(W)) u_recomp (
    .din  (fin_sum),
    .dout (sum_comp)
  );

  always_comb begin
    pre_val = fin_dcarry ? fin_sum : sum_comp;
    if (fin_tens == METH_TENS) begin
      inc_one = ~fin_dcarry;
    end else begin
      inc_one = fin_dcarry;
    end
  end

  bcd_digit_adder #(.W(W)) u_inc (
    .add_x      (pre_val),
    .add_y      ('0),
    .add_cin    (inc_one),
    .add_sum    (inc_sum),
    .add_dcarry (inc_wrap)
  );

  always_comb begin
    fin_mag = inc_sum;
    fin_neg = ~fin_dcarry & (inc_sum != '0);
  end

  always_comb begin
    if (fin_legal) begin
      AST_NO_INC_WRAP: assert (!inc_wrap); // R7
    end
  end
endmodule

// File: rtl/bcd_digit_subtractor.sv
`timescale 1ns/1ps
module bcd_digit_subtractor
  import bcd_sub_pkg::*;
#(
  parameter int W = BCD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_en,
  input  logic [W-1:0] dig_a,
  input  logic [W-1:0] dig_b,
  input  logic         use_tens,
  output logic [W-1:0] diff_mag,
  output logic         diff_neg,
  output logic         bad_digit
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_q;

  logic         a_bad;
  logic         b_bad;
  logic         in_bad;
  logic [W-1:0] b_comp;
  logic [W-1:0] dsum;
  logic         dcarry;
  logic [W-1:0] res_mag;
  logic         res_neg;

  logic [W-1:0] mag_q,  mag_d;
  logic         neg_q,  neg_d;
  logic         bad_q,  bad_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
    end
  end

  assign rst_q = rst_pipe[SYNC_N-1];

  always_comb begin
    a_bad  = int'(dig_a) > DEC_MAX;
    b_bad  = int'(dig_b) > DEC_MAX;
    in_bad = a_bad | b_bad;
  end

  bcd_nines_comp #(.W(W)) u_subcomp (
    .din  (dig_b),
    .dout (b_comp)
  );

  bcd_digit_adder #(.W(W)) u_add (
    .add_x      (dig_a),
    .add_y      (b_comp),
    .add_cin    (use_tens),
    .add_sum    (dsum),
    .add_dcarry (dcarry)
  );

  bcd_sub_finish #(.W(W)) u_fin (
    .fin_sum    (dsum),
    .fin_dcarry (dcarry),
    .fin_tens   (use_tens),
    .fin_legal  (~in_bad),
    .fin_mag    (res_mag),
    .fin_neg    (res_neg)
  );

  always_comb begin
    mag_d = mag_q;
    neg_d = neg_q;
    bad_d = bad_q;
    if (op_en) begin
      mag_d = res_mag;
      neg_d = res_neg;
      bad_d = in_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      mag_q <= '0;
      neg_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      mag_q <= mag_d;
      neg_q <= neg_d;
      bad_q <= bad_d;
    end
  end

  assign diff_mag  = mag_q;
  assign diff_neg  = neg_q;
  assign bad_digit = bad_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    !op_en |=> $stable({diff_mag, diff_neg, bad_digit})); // R2

  AST_MAG_MATCH: assert property (@(posedge clk) disable iff (!rst_q)
    (op_en && int'(dig_a) <= DEC_MAX && int'(dig_b) <= DEC_MAX) |=>
    (diff_mag == (($past(dig_a) >= $past(dig_b)) ?
                  ($past(dig_a) - $past(dig_b)) :
                  ($past(dig_b) - $past(dig_a))))); // R3

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_q)
    (op_en && int'(dig_a) <= DEC_MAX && int'(dig_b) <= DEC_MAX) |=>
    (diff_neg == ($past(dig_a) < $past(dig_b)))); // R4

  AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    diff_neg |-> (diff_mag != '0)); // R5

  AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_q)
    op_en |=> (bad_digit == (int'($past(dig_a)) > DEC_MAX ||
                             int'($past(dig_b)) > DEC_MAX))); // R6

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_q)
    !bad_digit |-> (int'(diff_mag) <= DEC_MAX)); // R7
endmodule

// File: tb/bcd_digit_subtractor_tb.sv
`timescale 1ns/1ps
module bcd_digit_subtractor_tb;
  logic       clk;
  logic       rst_n;
  logic       op_en;
  logic [3:0] dig_a;
  logic [3:0] dig_b;
  logic       use_tens;
  logic [3:0] diff_mag;
  logic       diff_neg;
  logic       bad_digit;

  typedef struct {
    int a;
    int b;
    int m;
    int bad;
    int mag;
    int neg;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk;
  int   n_fail;
  bit   pend;
  bit   done;
  bit   reported;

  bcd_digit_subtractor u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_en     (op_en),
    .dig_a     (dig_a),
    .dig_b     (dig_b),
    .use_tens  (use_tens),
    .diff_mag  (diff_mag),
    .diff_neg  (diff_neg),
    .bad_digit (bad_digit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  task automatic push_op(int a, int b, int m);
    exp_t e;
    @(negedge clk);
    dig_a    = 4'(a);
    dig_b    = 4'(b);
    use_tens = m[0];
    op_en    = 1'b1;
    e.a   = a;
    e.b   = b;
    e.m   = m;
    e.bad = (a > 9 || b > 9) ? 1 : 0;
    e.mag = (a >= b) ? a - b : b - a;
    e.neg = (a < b) ? 1 : 0;
    exp_q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_en = 1'b0;
    end
  endtask

  always @(posedge clk) pend <= op_en;

  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      exp_t e;
      string tag;
      e = exp_q.pop_front();
      check($sformatf("R6 bad flag a=%0d b=%0d", e.a, e.b), int'(bad_digit), e.bad);
      if (e.bad == 0) begin
        if (e.a == e.b) tag = "R5";
        else if (e.m == 1) tag = "R4";
        else tag = "R3";
        check($sformatf("%s mag a=%0d b=%0d m=%0d", tag, e.a, e.b, e.m),
              int'(diff_mag), e.mag);
        check($sformatf("%s sign a=%0d b=%0d m=%0d", tag, e.a, e.b, e.m),
              int'(diff_neg), e.neg);
        check($sformatf("R7 range a=%0d b=%0d m=%0d", e.a, e.b, e.m),
              (int'(diff_mag) <= 9) ? 1 : 0, 1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    done     = 1'b0;
    reported = 1'b0;
    rst_n    = 1'b0;
    op_en    = 1'b0;
    dig_a    = 4'd0;
    dig_b    = 4'd0;
    use_tens = 1'b0;

    repeat (3) @(negedge clk);
    check("R1 mag in reset", int'(diff_mag), 0);
    check("R1 neg in reset", int'(diff_neg), 0);
    check("R1 bad in reset", int'(bad_digit), 0);
    rst_n = 1'b1;
    dig_a = 4'd8;
    dig_b = 4'd2;
    idle(4);
    check("R1 mag after release", int'(diff_mag), 0);
    check("R1 neg after release", int'(diff_neg), 0);

    // Corner cases first, both methods: equal digits, nine minus zero, end-around increment
    for (int m = 0; m < 2; m++) begin
      push_op(5, 5, m);
      push_op(9, 0, m);
      push_op(0, 9, m);
      push_op(5, 4, m);
      push_op(4, 5, m);
      push_op(0, 0, m);
      push_op(9, 9, m);
    end
    idle(2);

    // Exhaustive legal sweep, back to back
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 10; a++) begin
        for (int b = 0; b < 10; b++) begin
          push_op(a, b, m);
        end
      end
    end
    idle(2);

    // Illegal codes 10..15 on either input
    push_op(10, 3, 0);
    push_op(2, 12, 1);
    push_op(15, 15, 0);
    push_op(9, 10, 1);
    push_op(3, 1, 0);
    idle(2);

    // R2: hold while op_en is low
    push_op(7, 3, 0);
    idle(1);
    dig_a    = 4'd0;
    dig_b    = 4'd9;
    use_tens = 1'b1;
    idle(4);
    check("R2 hold mag", int'(diff_mag), 4);
    check("R2 hold neg", int'(diff_neg), 0);
    check("R2 hold bad", int'(bad_digit), 0);

    // R1: reset in mid run clears a non-zero result
    push_op(1, 8, 1);
    idle(2);
    check("R1 pre-reset mag", int'(diff_mag), 7);
    rst_n = 1'b0;
    #2;
    check("R1 mid-run mag", int'(diff_mag), 0);
    check("R1 mid-run neg", int'(diff_neg), 0);
    idle(2);
    rst_n = 1'b1;
    idle(4);
    check("R1 after second release", int'(diff_mag), 0);
    push_op(2, 6, 0);
    idle(3);

    check("R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule